// File: doc/BRIEF.md
# Stream-to-Block Command Bridge

This block sits between a 32-bit word stream coming from a processor and a 128-bit command port of a cryptographic engine. The stream has no side channel for control, so each operation arrives as one instruction word followed by its operand words on the same stream. The bridge decodes the instruction and gathers the operand words into 128-bit blocks. It then launches the command with a start pulse and waits for a done pulse. The result is returned on a second 32-bit stream, either as a full block or as a single status word.

Both streams use a valid/ready handshake, and stalls are honoured on each side. The bridge handles one command at a time. It does not take the next instruction until every result word of the current command has been delivered. Clock-domain crossing buffers and the engine itself are outside the block.

Top module: `stream_cmd_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `s_ready` is 1, `m_valid` is 0 and `cmd_start` is 0.
- R2: In the instruction word, bits [7:0] are the opcode and bits [9:8] are the operand block count (0 to 3). At the start pulse, `cmd_opcode` and `cmd_nblk` carry these two fields. When the count is 0, `cmd_start` is high in the cycle that follows the instruction handshake.
- R3: Each operand block is taken from four consecutive accepted words, most significant word first. Block k appears in `cmd_operands[128k+127:128k]`. `cmd_start` is high in the cycle that follows the handshake of the last operand word.
- R4: Operand slots at or above the block count of the current instruction read as zero at the start pulse, even if an earlier command filled them.
- R5: An opcode with bits [7:6] equal to 2'b10 or 2'b11 returns the whole 128-bit `cmd_result` as four words, most significant first. The first word is valid in the cycle after `cmd_done` is sampled.
- R6: An opcode with bits [7:6] equal to 2'b01 returns exactly one word, equal to `cmd_result[31:0]`.
- R7: An opcode with bits [7:6] equal to 2'b00 produces no output word. The bridge accepts a new instruction after `cmd_done`.
- R8: While `m_ready` is low, `m_valid` and `m_data` hold their values. Each result word is delivered exactly once, and `m_valid` is low once the last word is taken.
- R9: Cycles with `s_valid` low are ignored. A word is consumed only in a cycle where `s_valid` and `s_ready` are both high.
- R10: From the handshake of the last input word of a command until its last result word has been taken, `s_ready` stays low. A waiting instruction is neither accepted nor started during that time.
- R11: `cmd_start` is a single-cycle pulse, issued exactly once per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 32 | Incoming instruction and operand words |
| s_valid | input | 1 | Incoming word is present |
| s_ready | output | 1 | Bridge takes the incoming word |
| m_data | output | 32 | Outgoing result word |
| m_valid | output | 1 | Outgoing word is present |
| m_ready | input | 1 | Consumer takes the outgoing word |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_opcode | output | 8 | Opcode of the current command |
| cmd_nblk | output | 2 | Operand block count of the current command |
| cmd_operands | output | 384 | Operand blocks, block k at bits 128k+127:128k |
| cmd_done | input | 1 | Engine finished, result valid |
| cmd_result | input | 128 | Result block from the engine |

## Verification
After an input handshake at a rising edge, `cmd_start` is due in the very next cycle. The bench reads it at the falling edge that directly follows the edge where the handshake took place. A result word is due one cycle after `cmd_done` is sampled, and `s_ready` returns one cycle after the final result handshake. The bench drives every input and samples every output only at falling edges, so each value it reads is the registered state left by the previous rising edge. A behavioural engine model in the bench takes a snapshot of the operand bus at the start pulse and answers a fixed number of cycles later. The expected words are built from the values the bench itself sent.

// File: rtl/stream_cmd_pkg.sv
package stream_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ISSUE,
    ST_WAIT,
    ST_DRAIN
  } ctrl_state_t;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_WORD,
    RES_BLOCK
  } res_kind_t;

  // Result class comes from the two top opcode bits.
  function automatic res_kind_t classify(input logic [1:0] cls);
    case (cls)
      2'b00:   return RES_NONE;
      2'b01:   return RES_WORD;
      default: return RES_BLOCK;
    endcase
  endfunction

endpackage

// File: rtl/operand_packer.sv
module operand_packer #(
  parameter int WORD_W  = 32,
  parameter int BLK_W   = 128,
  parameter int MAX_BLK = 3,
  parameter int CNT_W   = $clog2(MAX_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     push,
  input  logic [WORD_W-1:0]        word,
  input  logic [CNT_W-1:0]         nblk,
  output logic                     last,
  output logic [MAX_BLK*BLK_W-1:0] operands
);
  localparam int WPB    = BLK_W / WORD_W;
  localparam int WIDX_W = (WPB > 1) ? $clog2(WPB) : 1;

  logic [WIDX_W-1:0]       widx;
  logic [CNT_W-1:0]        bidx;
  logic [CNT_W-1:0]        bnext;
  logic [BLK_W-WORD_W-1:0] acc;
  logic [BLK_W-1:0]        acc_ext;
  logic                    blk_end;

  assign acc_ext = {acc, word};
  assign bnext   = bidx + 1'b1;
  assign blk_end = push && (widx == WIDX_W'(WPB - 1));
  assign last    = blk_end && (bnext == nblk);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      widx <= '0;
      bidx <= '0;
      acc  <= '0;
    end else if (push) begin
      acc <= acc_ext[BLK_W-WORD_W-1:0];
      if (blk_end) begin
        widx <= '0;
        bidx <= bnext;
      end else begin
        widx <= widx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MAX_BLK; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr)
        operands[g*BLK_W +: BLK_W] <= '0;
      else if (blk_end && (bidx == CNT_W'(g)))
        operands[g*BLK_W +: BLK_W] <= acc_ext;
    end
  end

  // Words never land beyond the announced block count.
  assert_pack_bound_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> (bidx < nblk));

endmodule

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              status_only,
  input  logic [BLK_W-1:0]  blk,
  output logic [WORD_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              empty
);
  localparam int WPB  = BLK_W / WORD_W;
  localparam int CW   = $clog2(WPB + 1);

  logic [BLK_W-1:0] sreg;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load) begin
      if (status_only) begin
        sreg <= {blk[WORD_W-1:0], {(BLK_W-WORD_W){1'b0}}};
        cnt  <= CW'(1);
      end else begin
        sreg <= blk;
        cnt  <= CW'(WPB);
      end
    end else if (m_valid && m_ready) begin
      sreg <= {sreg[BLK_W-WORD_W-1:0], {WORD_W{1'b0}}};
      cnt  <= cnt - 1'b1;
    end
  end

  assign m_data  = sreg[BLK_W-1 -: WORD_W];
  assign m_valid = (cnt != '0);
  assign empty   = (cnt == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_load_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> empty);

endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import stream_cmd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int OPC_W   = 8,
  parameter int MAX_BLK = 3,
  parameter int CNT_W   = $clog2(MAX_BLK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              pack_last,
  output logic              pack_clr,
  output logic              pack_push,
  output logic [CNT_W-1:0]  nblk,
  output logic              cmd_start,
  output logic [OPC_W-1:0]  cmd_opcode,
  input  logic              cmd_done,
  input  logic              ser_empty,
  output logic              ser_load,
  output logic              ser_status
);
  ctrl_state_t st, st_nx;
  res_kind_t   kind;
  logic [CNT_W-1:0] fld_cnt;
  logic             accept;

  assign fld_cnt = s_data[OPC_W +: CNT_W];
  assign s_ready = (st == ST_IDLE) || (st == ST_LOAD);
  assign accept  = (st == ST_IDLE) && s_valid;

  assign pack_clr   = accept;
  assign pack_push  = (st == ST_LOAD) && s_valid;
  assign cmd_start  = (st == ST_ISSUE);
  assign ser_load   = (st == ST_WAIT) && cmd_done && (kind != RES_NONE);
  assign ser_status = (kind == RES_WORD);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (s_valid) st_nx = (fld_cnt == '0) ? ST_ISSUE : ST_LOAD;
      ST_LOAD:  if (pack_last) st_nx = ST_ISSUE;
      ST_ISSUE: st_nx = ST_WAIT;
      ST_WAIT:  if (cmd_done) st_nx = (kind == RES_NONE) ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (ser_empty) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cmd_opcode <= '0;
      nblk       <= '0;
      kind       <= RES_NONE;
    end else begin
      st <= st_nx;
      if (accept) begin
        cmd_opcode <= s_data[OPC_W-1:0];
        nblk       <= (fld_cnt > CNT_W'(MAX_BLK)) ? CNT_W'(MAX_BLK) : fld_cnt;
        kind       <= classify(s_data[OPC_W-1 -: 2]);
      end
    end
  end

  assert_zero_blk_start_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && (fld_cnt == '0)) |=> cmd_start);

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !ser_empty |-> !s_ready);

endmodule

// File: rtl/stream_cmd_bridge.sv
module stream_cmd_bridge #(
  parameter int WORD_W  = 32,
  parameter int BLK_W   = 128,
  parameter int OPC_W   = 8,
  parameter int MAX_BLK = 3,
  parameter int CNT_W   = $clog2(MAX_BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WORD_W-1:0]        s_data,
  input  logic                     s_valid,
  output logic                     s_ready,
  output logic [WORD_W-1:0]        m_data,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     cmd_start,
  output logic [OPC_W-1:0]         cmd_opcode,
  output logic [CNT_W-1:0]         cmd_nblk,
  output logic [MAX_BLK*BLK_W-1:0] cmd_operands,
  input  logic                     cmd_done,
  input  logic [BLK_W-1:0]         cmd_result
);
  logic pack_last, pack_clr, pack_push;
  logic ser_empty, ser_load, ser_status;

  cmd_ctrl #(
    .WORD_W(WORD_W), .OPC_W(OPC_W), .MAX_BLK(MAX_BLK), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .pack_last(pack_last), .pack_clr(pack_clr), .pack_push(pack_push),
    .nblk(cmd_nblk), .cmd_start(cmd_start), .cmd_opcode(cmd_opcode),
    .cmd_done(cmd_done), .ser_empty(ser_empty),
    .ser_load(ser_load), .ser_status(ser_status)
  );

  operand_packer #(
    .WORD_W(WORD_W), .BLK_W(BLK_W), .MAX_BLK(MAX_BLK), .CNT_W(CNT_W)
  ) u_pack (
    .clk(clk), .rst(rst), .clr(pack_clr), .push(pack_push),
    .word(s_data), .nblk(cmd_nblk), .last(pack_last),
    .operands(cmd_operands)
  );

  result_serializer #(
    .WORD_W(WORD_W), .BLK_W(BLK_W)
  ) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .status_only(ser_status),
    .blk(cmd_result), .m_data(m_data), .m_valid(m_valid),
    .m_ready(m_ready), .empty(ser_empty)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (s_ready && !m_valid && !cmd_start));

endmodule

// File: tb/stream_cmd_bridge_test.sv
module stream_cmd_bridge_test;
  localparam int W = 32, B = 128, NB = 3, LAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic [W-1:0]    s_data, m_data;
  logic            s_valid, s_ready, m_valid, m_ready;
  logic            cmd_start, cmd_done;
  logic [7:0]      cmd_opcode;
  logic [1:0]      cmd_nblk;
  logic [NB*B-1:0] cmd_operands;
  logic [B-1:0]    cmd_result;

  int nchecks = 0, nerr = 0;

  stream_cmd_bridge uut (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_nblk(cmd_nblk),
    .cmd_operands(cmd_operands), .cmd_done(cmd_done), .cmd_result(cmd_result)
  );

  // Behavioural engine: snapshot at start, answer LAT cycles later.
  logic [7:0]      st_op;
  logic [1:0]      st_nblk;
  logic [NB*B-1:0] st_ops;
  int              st_lat;
  int              starts;

  always @(posedge clk) begin
    if (rst) begin
      st_lat <= 0; cmd_done <= 1'b0; starts <= 0;
      st_op <= '0; st_nblk <= '0; st_ops <= '0;
    end else begin
      cmd_done <= (st_lat == 1);
      if (cmd_start) begin
        st_lat <= LAT; st_ops <= cmd_operands; st_op <= cmd_opcode;
        st_nblk <= cmd_nblk; starts <= starts + 1;
      end else if (st_lat != 0) begin
        st_lat <= st_lat - 1;
      end
    end
  end

  assign cmd_result = st_ops[127:0] ^ st_ops[255:128] ^ st_ops[383:256] ^ {4{24'h0, st_op}};

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input int gap);
    repeat (gap) @(negedge clk);
    s_data = w; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic recv_word(output logic [W-1:0] w, input int stall);
    logic [W-1:0] held;
    m_ready = 1'b0;
    while (!m_valid) @(negedge clk);
    held = m_data;
    repeat (stall) @(negedge clk);
    if (stall > 0) chk(m_valid && m_data == held, "R8 hold under stall", {96'h0, m_data}, {96'h0, held});
    w = m_data;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int nblk, input int gap, input int stall);
    logic [W-1:0] wq [12];
    logic [B-1:0] slot [NB];
    logic [B-1:0] expr;
    logic [W-1:0] got;
    int s0, idle_ok;
    for (int i = 0; i < 12; i++) wq[i] = {op, 8'(i), 16'hA5C3 ^ 16'(i * 77)};
    for (int k = 0; k < NB; k++)
      slot[k] = (k < nblk) ? {wq[4*k], wq[4*k+1], wq[4*k+2], wq[4*k+3]} : '0;
    s0 = starts;
    send_word({22'h0, 2'(nblk), op}, 0);
    for (int i = 0; i < 4 * nblk; i++) send_word(wq[i], gap);
    chk(cmd_start == 1'b1, (nblk == 0) ? "R2 start after instruction" : "R3 start after last operand",
        {127'h0, cmd_start}, 128'h1);
    chk(s_ready == 1'b0, "R10 busy after last input", {127'h0, s_ready}, 128'h0);
    while (starts == s0 || st_lat != 0 || cmd_done) @(negedge clk);
    chk(st_op == op && st_nblk == 2'(nblk), "R2 opcode and count", {118'h0, st_nblk, st_op}, {118'h0, 2'(nblk), op});
    for (int k = 0; k < NB; k++)
      chk(st_ops[k*B +: B] == slot[k], (k < nblk) ? "R3 operand packing" : "R4 unused slot zero",
          st_ops[k*B +: B], slot[k]);
    expr = slot[0] ^ slot[1] ^ slot[2] ^ {4{24'h0, op}};
    if (op[7]) begin
      for (int i = 0; i < 4; i++) begin
        recv_word(got, stall);
        chk(got == expr[127 - 32*i -: 32], "R5 block word order", {96'h0, got}, {96'h0, expr[127 - 32*i -: 32]});
      end
    end else if (op[6]) begin
      recv_word(got, stall);
      chk(got == expr[31:0], "R6 status word", {96'h0, got}, {96'h0, expr[31:0]});
    end else begin
      idle_ok = 1;
      repeat (4) begin
        if (m_valid) idle_ok = 0;
        @(negedge clk);
      end
      chk(idle_ok == 1, "R7 no output words", {127'h0, !idle_ok[0]}, 128'h0);
    end
    chk(m_valid == 1'b0, "R8 no duplicate word", {127'h0, m_valid}, 128'h0);
    @(negedge clk);
    chk(s_ready == 1'b1, "R7 ready for next instruction", {127'h0, s_ready}, 128'h1);
    chk(starts == s0 + 1, "R11 one start per command", 128'(starts - s0), 128'h1);
  endtask

  task automatic test_busy();
    logic [W-1:0] got;
    int s0, okb;
    send_word({22'h0, 2'd1, 8'h91}, 0);
    for (int i = 0; i < 4; i++) send_word(32'h1000 + 32'(i), 0);
    while (!m_valid) @(negedge clk);
    s0 = starts;
    s_data = {22'h0, 2'd0, 8'h05}; s_valid = 1'b1;
    okb = 1;
    repeat (5) begin
      if (s_ready) okb = 0;
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      if (s_ready) okb = 0;
      recv_word(got, 1);
    end
    chk(okb == 1 && starts == s0, "R10 instruction held off while draining", 128'(starts - s0), 128'h0);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    chk(starts == s0 + 1, "R10 held instruction runs after drain", 128'(starts - s0), 128'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; s_valid = 1'b0; s_data = '0; m_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(s_ready && !m_valid && !cmd_start, "R1 reset state",
        {125'h0, s_ready, m_valid, cmd_start}, 128'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready && !m_valid && !cmd_start, "R1 state after reset",
        {125'h0, s_ready, m_valid, cmd_start}, 128'h4);
    run_cmd(8'h83, 2, 0, 0);
    run_cmd(8'hC1, 3, 2, 3);   // R9 input gaps, R8 output stalls
    run_cmd(8'h42, 1, 1, 2);   // R6 after a 3-block command: R4 clearing
    run_cmd(8'h10, 0, 0, 0);   // R7 and R2 zero-block start
    run_cmd(8'h7F, 0, 0, 1);
    run_cmd(8'hA4, 1, 3, 0);
    test_busy();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule